// File: doc/BRIEF.md
# Video Controller Register Bank with Timing Strobe Handshake

This block is the control register bank of a video controller. A host writes and reads 32-bit registers through a simple strobe bus. Each register sits in its own 16-byte slot, so the block only sees byte-offset bits 11:4 as a register index. The bus carries data in big-endian order, so the block byte-reverses every word in both directions. A host that writes a value and reads it back gets the same value, masked to the register's kept width.

The bank holds the raster timing parameters, the frame base, the row pitch, the miscellaneous enables, a two-bit clock divide and the interrupt enable and status. All of them drive level outputs for a timing engine that lives outside this block.

Two behaviours have their own handshakes:
- **Display on/off.** The host must give two rising edges of a reset-timing bit before the display state changes. The edges are counted from the last change of a disable-timing bit.
- **Vertical-blank interrupt.** The status bit tracks the incoming vertical-blank line. Software clears it by taking a clear bit in the interrupt enable register from 1 to 0.

Top module: `vidctl_regfile`

Register index map, with NTIM = 16:
- 0: current line
- 1..16: timing slots 0..15
- 17: counter test
- 18: timing control
- 19: frame base
- 20: row pitch
- 21: monitor sense
- 22: misc enables
- 23: clock divide
- 24: refresh count
- 25: interrupt enable
- 26: interrupt status

## Requirements
- R1: Write data on `bus_wdata` is byte-reversed before use. `bus_rdata` is the byte-reversed register value, registered one cycle after `bus_rd`. A frame base write of raw bus word 0x20001000 gives `frame_base` = 0x100020.
- R2: Timing slots keep the low bits of the written value and read back masked: slot PIPE_SLOT (7) keeps 10 bits, slot HEQ_SLOT (13) keeps 8 bits, and every other slot keeps 12 bits. `timing_vals` slot k occupies bits k*12 +: 12.
- R3: `param_err` pulses for one cycle after a timing-slot write whose value has any bit set above that slot's kept width. No other write raises it.
- R4: Widths of the other registers:
  - frame base is masked with 0x3FFFE0;
  - row pitch is masked with 0x7FE0;
  - clock divide keeps 2 bits;
  - misc enables keep 12 bits;
  - timing control keeps 11 bits;
  - interrupt enable keeps 4 bits.

  Each of these reads back its masked value and drives it on its output port.
- R5: In timing control, bit 0 is reset-timing and bit 1 is disable-timing. A write that changes bit 1 stores the value and clears the strobe count. Otherwise, a write that takes bit 0 from 0 to 1 advances the count, which saturates at 2. When the count reaches 2, `disp_on` becomes the inverse of the written bit 1.
- R6: A timing control write that changes neither bit 0 nor bit 1, or that takes bit 0 from 1 to 0, leaves the count and `disp_on` unchanged.
- R7: `blank` is 1 after reset. A misc enables write that changes bit 3 drives `blank` to the inverse of the new bit 3. Writes that leave bit 3 unchanged keep `blank`.
- R8: The VBL status (interrupt status bit 0) becomes 1 after a rising edge of `vbl_line` and 0 after a falling edge. It is also cleared by an interrupt enable write that takes bit 2 from 1 to 0. If a line edge and a clear land in the same cycle, the edge wins.
- R9: `irq` is 1 exactly when the VBL status and interrupt enable bit 0 are both 1.
- R10: The current line, counter test and refresh count registers, and any unmapped index, read as 0. Writes to them change nothing.
- R11: The monitor sense register stores 6 bits. It reads back as `mon_id` in bits 8:6 above the stored sense bits.
- R12: A write to a timing slot, frame base, row pitch or clock divide while `disp_on` is 1 pulses `reconfig` for one cycle. No pulse occurs while `disp_on` is 0, and writes to other registers never pulse it.
- R13: After reset all registers are 0, `disp_on`, `irq`, `reconfig` and `param_err` are 0, and `blank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_idx | input | 8 | Register index (byte offset bits 11:4) |
| bus_wdata | input | 32 | Write data, big-endian byte order |
| bus_rdata | output | 32 | Read data, big-endian byte order, one cycle after bus_rd |
| vbl_line | input | 1 | Vertical-blank line from the timing engine |
| mon_id | input | 3 | Detected monitor id |
| timing_vals | output | NTIM*12 | Timing slot values, 12 bits per slot |
| frame_base | output | 22 | Frame base register |
| row_pitch | output | 15 | Row pitch register |
| misc_en | output | 12 | Miscellaneous enables |
| clk_div | output | 2 | Clock divide field |
| disp_on | output | 1 | Display timing enabled |
| blank | output | 1 | Display blanked |
| irq | output | 1 | Vertical-blank interrupt request |
| reconfig | output | 1 | One-cycle pulse: geometry changed while the display is on |
| param_err | output | 1 | One-cycle pulse: timing write had bits above the kept width |

## Verification
The bench builds the default configuration: sixteen timing slots, with the 10-bit slot at 7 and the 8-bit slot at 13. This is small enough to sweep every slot with over-range and in-range values, and to walk a single set bit across all 32 write positions of every masked register. It also steps the strobe handshake through every ordering of count, disable change and saturation, and runs the VBL clear against a line that is still high.

// File: rtl/vidctl_pkg.sv
// Shared constants for the video control register bank.
// Assumes a 32-bit big-endian host bus; bit positions here are behavioural.
package vidctl_pkg;
    localparam int IDX_W      = 8;
    localparam int TCTL_W     = 11;
    localparam int TCTL_RST   = 0;
    localparam int TCTL_DIS   = 1;
    localparam int MISC_W     = 12;
    localparam int MISC_UNBLK = 3;
    localparam int IEN_W      = 4;
    localparam int IEN_VBL    = 0;
    localparam int IEN_CLR    = 2;
    localparam int FBASE_W    = 22;
    localparam logic [FBASE_W-1:0] FBASE_MASK = 22'h3FFFE0;
    localparam int PITCH_W    = 15;
    localparam logic [PITCH_W-1:0] PITCH_MASK = 15'h7FE0;
    localparam int DIV_W      = 2;
    localparam int SENSE_W    = 6;
    localparam int MONID_W    = 3;

    // Reverse the byte order of a 32-bit bus word.
    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
endpackage

// File: rtl/vidctl_timing_bank.sv
// Timing parameter slots. Each slot keeps a per-slot number of low bits.
// Assumes write data is already byte-reversed; err_o pulses one cycle after
// a write carrying bits above the addressed slot's kept width.
module vidctl_timing_bank #(
    parameter int NTIM      = 16,
    parameter int TW        = 12,
    parameter int PIPE_SLOT = 7,
    parameter int PIPE_W    = 10,
    parameter int HEQ_SLOT  = 13,
    parameter int HEQ_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NTIM)-1:0]  slot,
    input  logic [31:0]              wdata,
    output logic [NTIM*TW-1:0]       vals,
    output logic                     err_o
);
    localparam int SW = $clog2(NTIM);

    logic [NTIM-1:0] over;

    for (genvar k = 0; k < NTIM; k++) begin : g_slot
        localparam int KW = (k == PIPE_SLOT) ? PIPE_W : ((k == HEQ_SLOT) ? HEQ_W : TW);
        logic [TW-1:0] r;
        // Capture the kept bits of a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                r <= '0;
            else if (wr_en && slot == SW'(k))
                r <= TW'(wdata[KW-1:0]);
        end
        assign vals[k*TW +: TW] = r;
        assign over[k] = |wdata[31:KW];
    end

    // Flag a write that carried bits the addressed slot drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else
            err_o <= wr_en && over[slot];
    end
endmodule

// File: rtl/vidctl_strobe.sv
// Timing control register and display-enable handshake.
// The display state changes only once two rising edges of the reset-timing bit
// have been seen since the disable-timing bit last changed.
module vidctl_strobe
    import vidctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TCTL_W-1:0] wdata,
    output logic [TCTL_W-1:0] ctl_o,
    output logic              disp_o
);
    logic [1:0]        cnt;
    logic [1:0]        cnt_up;
    logic [TCTL_W-1:0] diff;

    assign diff   = ctl_o ^ wdata;
    assign cnt_up = (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;

    // Store the control word and run the strobe counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o  <= '0;
            cnt    <= 2'd0;
            disp_o <= 1'b0;
        end else if (wr_en) begin
            ctl_o <= wdata;
            if (diff[TCTL_DIS]) begin
                cnt <= 2'd0;
            end else if (diff[TCTL_RST] && wdata[TCTL_RST]) begin
                cnt <= cnt_up;
                if (cnt_up == 2'd2)
                    disp_o <= !wdata[TCTL_DIS];
            end
        end
    end
endmodule

// File: rtl/vidctl_irq.sv
// Vertical-blank status and interrupt gating.
// Status follows edges of the blank line; a 1-to-0 change of the clear bit
// in the enable register drops it. A line edge wins over a same-cycle clear.
module vidctl_irq
    import vidctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vbl_line,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_new,
    output logic [IEN_W-1:0] ien_o,
    output logic             stat_o,
    output logic             irq_o
);
    logic vb_q;
    logic clr_evt;

    assign clr_evt = ien_wr && ien_o[IEN_CLR] && !ien_new[IEN_CLR];

    // Hold the interrupt enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_o <= '0;
        else if (ien_wr)
            ien_o <= ien_new;
    end

    // Track line edges and the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q   <= 1'b0;
            stat_o <= 1'b0;
        end else begin
            vb_q <= vbl_line;
            if (vbl_line && !vb_q)
                stat_o <= 1'b1;
            else if (!vbl_line && vb_q)
                stat_o <= 1'b0;
            else if (clr_evt)
                stat_o <= 1'b0;
        end
    end

    assign irq_o = stat_o && ien_o[IEN_VBL];
endmodule

// File: rtl/vidctl_regfile.sv
// Video controller register bank: decode, masking, read mux, blank level
// and reconfigure pulse. Assumes single-cycle write strobes and registers
// at 16-byte strides, addressed by bus_idx = offset[11:4].
module vidctl_regfile
    import vidctl_pkg::*;
#(
    parameter int NTIM      = 16,
    parameter int TW        = 12,
    parameter int PIPE_SLOT = 7,
    parameter int PIPE_W    = 10,
    parameter int HEQ_SLOT  = 13,
    parameter int HEQ_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [IDX_W-1:0]     bus_idx,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 vbl_line,
    input  logic [MONID_W-1:0]   mon_id,
    output logic [NTIM*TW-1:0]   timing_vals,
    output logic [FBASE_W-1:0]   frame_base,
    output logic [PITCH_W-1:0]   row_pitch,
    output logic [MISC_W-1:0]    misc_en,
    output logic [DIV_W-1:0]     clk_div,
    output logic                 disp_on,
    output logic                 blank,
    output logic                 irq,
    output logic                 reconfig,
    output logic                 param_err
);
    localparam int SW = $clog2(NTIM);
    localparam logic [IDX_W-1:0] I_LINE  = 8'd0;
    localparam logic [IDX_W-1:0] I_TLO   = 8'd1;
    localparam logic [IDX_W-1:0] I_THI   = IDX_W'(NTIM);
    localparam logic [IDX_W-1:0] I_CTEST = IDX_W'(NTIM + 1);
    localparam logic [IDX_W-1:0] I_TCTL  = IDX_W'(NTIM + 2);
    localparam logic [IDX_W-1:0] I_FBASE = IDX_W'(NTIM + 3);
    localparam logic [IDX_W-1:0] I_PITCH = IDX_W'(NTIM + 4);
    localparam logic [IDX_W-1:0] I_SENSE = IDX_W'(NTIM + 5);
    localparam logic [IDX_W-1:0] I_MISC  = IDX_W'(NTIM + 6);
    localparam logic [IDX_W-1:0] I_DIV   = IDX_W'(NTIM + 7);
    localparam logic [IDX_W-1:0] I_REFR  = IDX_W'(NTIM + 8);
    localparam logic [IDX_W-1:0] I_IEN   = IDX_W'(NTIM + 9);
    localparam logic [IDX_W-1:0] I_ISTAT = IDX_W'(NTIM + 10);

    logic [31:0]          wsw;
    logic                 is_tim;
    logic [SW-1:0]        slot;
    logic [TCTL_W-1:0]    tctl;
    logic [SENSE_W-1:0]   sense_q;
    logic [IEN_W-1:0]     ien_q;
    logic                 vbl_stat;
    logic                 geo_wr;
    logic [31:0]          rd_val;
    logic [TW-1:0]        tim_rd;

    assign wsw    = bswap32(bus_wdata);
    assign is_tim = (bus_idx >= I_TLO) && (bus_idx <= I_THI);
    assign slot   = SW'(bus_idx - I_TLO);
    assign geo_wr = bus_wr && (is_tim || bus_idx == I_FBASE || bus_idx == I_PITCH
                               || bus_idx == I_DIV);
    assign tim_rd = timing_vals[slot*TW +: TW];

    vidctl_timing_bank #(
        .NTIM(NTIM), .TW(TW), .PIPE_SLOT(PIPE_SLOT), .PIPE_W(PIPE_W),
        .HEQ_SLOT(HEQ_SLOT), .HEQ_W(HEQ_W)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && is_tim), .slot(slot),
        .wdata(wsw), .vals(timing_vals), .err_o(param_err)
    );

    vidctl_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && bus_idx == I_TCTL),
        .wdata(wsw[TCTL_W-1:0]), .ctl_o(tctl), .disp_o(disp_on)
    );

    vidctl_irq u_irq (
        .clk(clk), .rst_n(rst_n), .vbl_line(vbl_line),
        .ien_wr(bus_wr && bus_idx == I_IEN), .ien_new(wsw[IEN_W-1:0]),
        .ien_o(ien_q), .stat_o(vbl_stat), .irq_o(irq)
    );

    // Plain masked registers: frame base, pitch, divide, sense, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_base <= '0;
            row_pitch  <= '0;
            clk_div    <= '0;
            sense_q    <= '0;
            misc_en    <= '0;
        end else if (bus_wr) begin
            if (bus_idx == I_FBASE) frame_base <= wsw[FBASE_W-1:0] & FBASE_MASK;
            if (bus_idx == I_PITCH) row_pitch  <= wsw[PITCH_W-1:0] & PITCH_MASK;
            if (bus_idx == I_DIV)   clk_div    <= wsw[DIV_W-1:0];
            if (bus_idx == I_SENSE) sense_q    <= wsw[SENSE_W-1:0];
            if (bus_idx == I_MISC)  misc_en    <= wsw[MISC_W-1:0];
        end
    end

    // Blank level follows changes of the unblank enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blank <= 1'b1;
        else if (bus_wr && bus_idx == I_MISC && (misc_en[MISC_UNBLK] ^ wsw[MISC_UNBLK]))
            blank <= !wsw[MISC_UNBLK];
    end

    // Pulse when display geometry is rewritten while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reconfig <= 1'b0;
        else
            reconfig <= geo_wr && disp_on;
    end

    // Select the register value for a read.
    always_comb begin
        rd_val = '0;
        if (is_tim)
            rd_val = 32'(tim_rd);
        else begin
            case (bus_idx)
                I_TCTL:  rd_val = 32'(tctl);
                I_FBASE: rd_val = 32'(frame_base);
                I_PITCH: rd_val = 32'(row_pitch);
                I_SENSE: rd_val = 32'({mon_id, sense_q});
                I_MISC:  rd_val = 32'(misc_en);
                I_DIV:   rd_val = 32'(clk_div);
                I_IEN:   rd_val = 32'(ien_q);
                I_ISTAT: rd_val = 32'(vbl_stat);
                I_LINE, I_CTEST, I_REFR: rd_val = '0;
                default: rd_val = '0;
            endcase
        end
    end

    // Register read data in bus byte order.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= bswap32(rd_val);
    end
endmodule

// File: rtl/vidctl_regfile_chk.sv
// Temporal checks for the video control register bank, bound to the top.
module vidctl_regfile_chk #(
    parameter int NTIM = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_idx,
    input logic       disp_on,
    input logic       blank,
    input logic       irq,
    input logic       ien_vbl,
    input logic       vbl_stat,
    input logic       vbl_line,
    input logic       reconfig,
    input logic       param_err
);
    localparam logic [7:0] C_TCTL = 8'(NTIM + 2);
    localparam logic [7:0] C_MISC = 8'(NTIM + 6);
    localparam logic [7:0] C_THI  = 8'(NTIM);

    AST_DISP_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_on) |-> ($past(bus_wr) && $past(bus_idx) == C_TCTL)); // R5
    AST_BLANK_BY_MISC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blank) |-> ($past(bus_wr) && $past(bus_idx) == C_MISC)); // R7
    AST_VBL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbl_line) |=> vbl_stat); // R8
    AST_VBL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vbl_line) |=> !vbl_stat); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_vbl |-> !irq); // R9
    AST_RECONF_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |-> $past(disp_on)); // R12
    AST_ERR_FROM_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        param_err |-> ($past(bus_wr) && $past(bus_idx) >= 8'd1 && $past(bus_idx) <= C_THI)); // R3
endmodule

bind vidctl_regfile vidctl_regfile_chk #(.NTIM(NTIM)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .disp_on(disp_on), .blank(blank), .irq(irq), .ien_vbl(ien_q[0]),
    .vbl_stat(vbl_stat), .vbl_line(vbl_line), .reconfig(reconfig),
    .param_err(param_err)
);

// File: tb/tb_vidctl_regfile.sv
`timescale 1ns/1ps
module tb_vidctl_regfile;
    localparam int NTIM = 16;
    localparam int TW   = 12;
    localparam logic [7:0] X_LINE = 0, X_CTEST = 17, X_TCTL = 18, X_FBASE = 19,
        X_PITCH = 20, X_SENSE = 21, X_MISC = 22, X_DIV = 23, X_REFR = 24,
        X_IEN = 25, X_ISTAT = 26;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, vbl_line = 0;
    logic [7:0]  bus_idx = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [2:0]  mon_id = 0;
    logic [NTIM*TW-1:0] timing_vals;
    logic [21:0] frame_base;
    logic [14:0] row_pitch;
    logic [11:0] misc_en;
    logic [1:0]  clk_div;
    logic disp_on, blank, irq, reconfig, param_err;
    logic last_rc, last_err;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    vidctl_regfile dut (.*);

    function automatic logic [31:0] sw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1; bus_idx = idx; bus_wdata = sw(v);
        @(negedge clk);
        bus_wr = 0;
        last_rc = reconfig; last_err = param_err;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1; bus_idx = idx;
        @(negedge clk);
        bus_rd = 0;
        v = sw(bus_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; vbl_line = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    function automatic int kw(input int s);
        return (s == 7) ? 10 : ((s == 13) ? 8 : 12);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] r, pat, m;
        do_reset();
        // R13 reset state
        chk("R13 disp_on", 32'(disp_on), 0);
        chk("R13 blank", 32'(blank), 1);
        chk("R13 irq", 32'(irq), 0);
        chk("R13 reconfig", 32'(reconfig), 0);
        chk("R13 param_err", 32'(param_err), 0);
        rd(X_TCTL, r); chk("R13 tctl", r, 0);
        rd(X_FBASE, r); chk("R13 fbase", r, 0);

        // R1 raw byte order
        @(negedge clk); bus_wr = 1; bus_idx = X_FBASE; bus_wdata = 32'h20001000;
        @(negedge clk); bus_wr = 0;
        chk("R1 frame_base", 32'(frame_base), 32'h100020);
        @(negedge clk); bus_rd = 1; bus_idx = X_FBASE;
        @(negedge clk); bus_rd = 0;
        chk("R1 raw rdata", bus_rdata, 32'h20001000);

        // R2/R3 sweep of every timing slot
        for (int s = 0; s < NTIM; s++) begin
            for (int p = 0; p < 4; p++) begin
                pat = (p == 0) ? 32'hFFFFFFFF : (p == 1) ? 32'h000000A5 :
                      (p == 2) ? 32'h00000ABC : 32'h00000345;
                wr(8'(s + 1), pat);
                m = (32'd1 << kw(s)) - 1;
                chk("R3 param_err", 32'(last_err), 32'((pat & ~m) != 0));
                rd(8'(s + 1), r);
                chk("R2 slot readback", r, pat & m);
                chk("R2 timing_vals", 32'(timing_vals[s*TW +: TW]), pat & m);
            end
        end

        // R4 single-bit walk over masked registers
        for (int b = 0; b < 32; b++) begin
            pat = 32'd1 << b;
            wr(X_FBASE, pat); rd(X_FBASE, r);
            chk("R4 fbase", r, pat & 32'h3FFFE0);
            chk("R4 frame_base port", 32'(frame_base), pat & 32'h3FFFE0);
            chk("R3 no err on fbase", 32'(last_err), 0);
            wr(X_PITCH, pat); rd(X_PITCH, r);
            chk("R4 pitch", r, pat & 32'h7FE0);
            chk("R4 row_pitch port", 32'(row_pitch), pat & 32'h7FE0);
            wr(X_DIV, pat); rd(X_DIV, r);
            chk("R4 div", r, pat & 32'h3);
            chk("R4 clk_div port", 32'(clk_div), pat & 32'h3);
            wr(X_MISC, pat); rd(X_MISC, r);
            chk("R4 misc", r, pat & 32'hFFF);
            chk("R4 misc_en port", 32'(misc_en), pat & 32'hFFF);
            wr(X_TCTL, pat); rd(X_TCTL, r);
            chk("R4 tctl", r, pat & 32'h7FF);
            wr(X_IEN, pat); rd(X_IEN, r);
            chk("R4 ien", r, pat & 32'hF);
        end

        // R10 zero-reading registers, writes change nothing
        do_reset();
        wr(X_CTEST, 32'hFFF); wr(X_REFR, 32'h1234); wr(X_LINE, 32'hFFFFFFFF);
        wr(8'h40, 32'hFFFFFFFF);
        rd(X_LINE, r);  chk("R10 line", r, 0);
        rd(X_CTEST, r); chk("R10 ctest", r, 0);
        rd(X_REFR, r);  chk("R10 refresh", r, 0);
        rd(8'h40, r);   chk("R10 unknown 0x40", r, 0);
        rd(8'hFF, r);   chk("R10 unknown 0xFF", r, 0);
        rd(X_TCTL, r);  chk("R10 tctl untouched", r, 0);
        chk("R10 blank untouched", 32'(blank), 1);

        // R11 monitor sense
        mon_id = 3'd5; wr(X_SENSE, 32'h2A); rd(X_SENSE, r);
        chk("R11 sense", r, (32'd5 << 6) | 32'h2A);
        mon_id = 3'd2; wr(X_SENSE, 32'hFF); rd(X_SENSE, r);
        chk("R11 sense masked", r, (32'd2 << 6) | 32'h3F);

        // R12 no pulse while off
        wr(8'd1, 32'h10); chk("R12 off timing", 32'(last_rc), 0);
        wr(X_FBASE, 32'h40); chk("R12 off fbase", 32'(last_rc), 0);

        // R5/R6 strobe handshake
        wr(X_TCTL, 32'h1); chk("R5 one edge", 32'(disp_on), 0);
        wr(X_TCTL, 32'h0); chk("R6 falling edge", 32'(disp_on), 0);
        wr(X_TCTL, 32'h1); chk("R5 two edges on", 32'(disp_on), 1);
        wr(X_TCTL, 32'h7F1); chk("R6 other bits", 32'(disp_on), 1);
        rd(X_TCTL, r); chk("R6 tctl stored", r, 32'h7F1);
        wr(X_TCTL, 32'h001); chk("R6 other bits back", 32'(disp_on), 1);

        // R12 pulses while on
        wr(8'd5, 32'h20);    chk("R12 timing on", 32'(last_rc), 1);
        wr(X_FBASE, 32'h40); chk("R12 fbase on", 32'(last_rc), 1);
        wr(X_PITCH, 32'h40); chk("R12 pitch on", 32'(last_rc), 1);
        wr(X_DIV, 32'h1);    chk("R12 div on", 32'(last_rc), 1);
        wr(X_SENSE, 32'h1);  chk("R12 sense no pulse", 32'(last_rc), 0);
        chk("R12 pulse one cycle", 32'(reconfig), 0);

        wr(X_TCTL, 32'h3); chk("R5 dis change clears", 32'(disp_on), 1);
        wr(X_TCTL, 32'h2);
        wr(X_TCTL, 32'h3); chk("R5 count one after clear", 32'(disp_on), 1);
        wr(X_TCTL, 32'h2);
        wr(X_TCTL, 32'h3); chk("R5 disable commit", 32'(disp_on), 0);
        wr(X_TCTL, 32'h2);
        wr(X_TCTL, 32'h3); chk("R5 saturated recommit", 32'(disp_on), 0);
        wr(X_TCTL, 32'h1); chk("R5 dis change with rst", 32'(disp_on), 0);
        wr(X_TCTL, 32'h0);
        wr(X_TCTL, 32'h1); chk("R5 one edge again", 32'(disp_on), 0);
        wr(X_TCTL, 32'h0);
        wr(X_TCTL, 32'h1); chk("R5 enable again", 32'(disp_on), 1);

        // R7 blank
        wr(X_MISC, 32'h008); chk("R7 unblank", 32'(blank), 0);
        wr(X_MISC, 32'h00C); chk("R7 bit unchanged", 32'(blank), 0);
        wr(X_MISC, 32'h000); chk("R7 blank again", 32'(blank), 1);
        wr(X_MISC, 32'h004); chk("R7 other bit", 32'(blank), 1);

        // R8/R9 vertical blank
        @(negedge clk); vbl_line = 1;
        @(negedge clk); @(negedge clk);
        rd(X_ISTAT, r); chk("R8 status rise", r, 1);
        chk("R9 masked", 32'(irq), 0);
        wr(X_IEN, 32'h1); chk("R9 enabled", 32'(irq), 1);
        @(negedge clk); vbl_line = 0;
        @(negedge clk); @(negedge clk);
        chk("R8 status fall", 32'(irq), 0);
        @(negedge clk); vbl_line = 1;
        @(negedge clk); @(negedge clk);
        chk("R8 rise again", 32'(irq), 1);
        wr(X_IEN, 32'h5); chk("R8 clear bit set", 32'(irq), 1);
        wr(X_IEN, 32'h1); chk("R8 clear falling", 32'(irq), 0);
        rd(X_ISTAT, r); chk("R8 status cleared line high", r, 0);
        wr(X_IEN, 32'h1); chk("R8 no re-clear effect", 32'(irq), 0);
        @(negedge clk); vbl_line = 0;
        @(negedge clk); vbl_line = 1;
        @(negedge clk); @(negedge clk);
        chk("R9 irq after new rise", 32'(irq), 1);
        wr(X_IEN, 32'h0); chk("R9 disable gates", 32'(irq), 0);
        rd(X_ISTAT, r); chk("R8 status kept", r, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule